// File: doc/BRIEF.md
# Indexed effective address generator

This block turns a 36-bit instruction word into a 15-bit effective address for a word-addressed machine whose addresses are indexed by tag-selected index registers. Each accepted command subtracts the contents chosen by the word's 3-bit tag from its 15-bit address field. It can also take the address field unmodified, for the index-control form. When both flag bits are set, the block makes one indirect reference: it reads a second word from memory and recomputes the address from that word's tag and address fields.

The block holds seven 15-bit index registers and a mode bit. After reset the block combines registers: every set tag bit selects one of three registers, and their contents are ORed together. A leave command switches the block to single selection, where the tag value names one of all seven registers. A separate load port writes the decrement field of a load word into the registers its tag selects. Loads and the leave command can arrive in any cycle, including a cycle in which an address is being formed.

Top module: `ea_gen`

## Requirements
- R1: After synchronous reset, `done`, `busy` and `mem_req` are low, all index registers hold zero and the block is in combining mode. A computation with any tag then yields the address field unchanged.
- R2: Bit 35 of a word is its leftmost bit. The address field is bits [14:0], the tag is [17:15], the flag is [23:22] and the decrement field is [32:18]. All other bits have no effect on the result.
- R3: A command accepted while idle (`start` high, `busy` low) that is not indirect raises `done` for one cycle in the next cycle, with `ea` valid. Commands may be issued back to back.
- R4: In combining mode, the subtracted value is the OR of register 1 (if tag bit [15] is set), register 2 (if tag bit [16] is set) and register 4 (if tag bit [17] is set). A tag of zero subtracts nothing, and the difference wraps modulo 2^15.
- R5: After `mt_leave`, tag value n (1 to 7) selects register n alone and tag 0 subtracts nothing. Only reset returns the block to combining mode.
- R6: With `idx_ctl` high, `ea` is the address field alone, whatever the tag and flag.
- R7: A flag of 2'b11 with `idx_ctl` low raises `mem_req` for exactly one cycle, the cycle after acceptance, with `mem_addr` set to the indexed address. In the cycle after `mem_rvalid`, `done` rises and `ea` holds the fetched word's address field minus its tag selection. The fetched word's flag is ignored.
- R8: When `ld_en` is high, the decrement field of `ld_word` is written to the registers its tag selects. In combining mode these are registers 1, 2 and 4 for tag bits [15], [16] and [17], and every selected register is written. In single mode only register `tag` is written. A tag of 0 writes nothing.
- R9: An address step in the same cycle as a load or `mt_leave` uses the register contents and mode from before that update. A load during an indirect wait is seen by the second step.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a command from `instr` |
| instr | input | 36 | Instruction word |
| idx_ctl | input | 1 | Index-control form: address field only |
| ld_en | input | 1 | Load index registers |
| ld_word | input | 36 | Load word (tag and decrement fields used) |
| mt_leave | input | 1 | Leave combining mode |
| mem_req | output | 1 | Indirect read request, one cycle |
| mem_addr | output | 15 | Indirect read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 36 | Read data word |
| busy | output | 1 | Indirect reference in progress |
| done | output | 1 | `ea` is final, one cycle |
| ea | output | 15 | Effective address |

## Verification
The collision of interest is an index register load, or the leave command, in the same cycle as an address step that reads the register or mode being changed. The bench drives `ld_en`, `mt_leave` and `start` together on the same tag, and it also loads during an indirect wait. A cycle-accurate behavioural model applies the address step before the update on each edge. It is compared with `ea`, `done`, `busy` and the memory request on every clock.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W   = 36;
    localparam int ADDR_W   = 15;
    localparam int TAG_W    = 3;
    localparam int FLAG_W   = 2;
    localparam int GAP_W    = 4;
    localparam int DEC_W    = 15;
    localparam int NUM_XR   = (1 << TAG_W) - 1;
    localparam int Y_LSB    = 0;
    localparam int TAG_LSB  = Y_LSB + ADDR_W;
    localparam int DEC_LSB  = TAG_LSB + TAG_W;
    localparam int FLAG_LSB = TAG_LSB + TAG_W + GAP_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [FLAG_W-1:0] flag_t;

    localparam flag_t FLAG_IND = '1;

    typedef struct packed {
        flag_t flag;
        tag_t  tag;
        addr_t y;
        logic [DEC_W-1:0] dec;
    } fields_t;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_t;

    function automatic fields_t split_word(word_t w);
        fields_t f;
        f.flag = w[FLAG_LSB +: FLAG_W];
        f.tag  = w[TAG_LSB  +: TAG_W];
        f.y    = w[Y_LSB    +: ADDR_W];
        f.dec  = w[DEC_LSB  +: DEC_W];
        return f;
    endfunction

    // Register idx is chosen by tag: in combining mode only power-of-two
    // registers exist and each set tag bit picks one; otherwise tag == idx.
    function automatic logic xr_hit(logic multi, tag_t tag, int idx);
        if (multi)
            return ((idx & (idx - 1)) == 0) && ((int'(tag) & idx) != 0);
        return int'(tag) == idx;
    endfunction
endpackage

// File: rtl/ea_xrf.sv
module ea_xrf
    import ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_en,
    input  tag_t  ld_tag,
    input  addr_t ld_val,
    input  logic  leave,
    input  tag_t  rd_tag,
    output addr_t rd_val,
    output logic  multi
);
    logic                        multi_q;
    logic [NUM_XR:1][ADDR_W-1:0] xr_q;
    logic [NUM_XR:1]             wr_mask;
    logic [NUM_XR:1]             rd_mask;

    generate
        for (genvar i = 1; i <= NUM_XR; i++) begin : g_sel
            assign wr_mask[i] = ld_en && xr_hit(multi_q, ld_tag, i);
            assign rd_mask[i] = xr_hit(multi_q, rd_tag, i);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            multi_q <= 1'b1;
            xr_q    <= '0;
        end else begin
            if (leave)
                multi_q <= 1'b0;
            for (int i = 1; i <= NUM_XR; i++)
                if (wr_mask[i])
                    xr_q[i] <= ld_val;
        end
    end

    // In single mode at most one hit, so the OR also serves as a mux.
    always_comb begin
        rd_val = '0;
        for (int i = 1; i <= NUM_XR; i++)
            if (rd_mask[i])
                rd_val = rd_val | xr_q[i];
    end

    assign multi = multi_q;

    AST_TAG0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_tag == '0) |=> $stable(xr_q)); // R8
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !multi_q |=> !multi_q); // R5
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  fields_t cmd_f,
    input  logic    idx_ctl,
    input  logic    mem_rvalid,
    input  fields_t mem_f,
    input  addr_t   ct,
    output tag_t    rd_tag,
    output logic    mem_req,
    output addr_t   mem_addr,
    output logic    busy,
    output logic    done,
    output addr_t   ea
);
    seq_t  state_q;
    addr_t sel_y;
    addr_t diff;

    assign sel_y  = (state_q == SEQ_WAIT) ? mem_f.y   : cmd_f.y;
    assign rd_tag = (state_q == SEQ_WAIT) ? mem_f.tag : cmd_f.tag;
    assign diff   = sel_y - ct;
    assign busy   = (state_q == SEQ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            ea       <= '0;
        end else begin
            mem_req <= 1'b0;
            done    <= 1'b0;
            case (state_q)
                SEQ_IDLE: if (start) begin
                    if (idx_ctl) begin
                        ea   <= cmd_f.y;
                        done <= 1'b1;
                    end else if (cmd_f.flag == FLAG_IND) begin
                        mem_addr <= diff;
                        mem_req  <= 1'b1;
                        state_q  <= SEQ_WAIT;
                    end else begin
                        ea   <= diff;
                        done <= 1'b1;
                    end
                end
                SEQ_WAIT: if (mem_rvalid) begin
                    ea      <= diff;
                    done    <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (idx_ctl || cmd_f.flag != FLAG_IND)) |=> done); // R3
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R7
    AST_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R7
    AST_DATA_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rvalid) |=> (done && !busy)); // R7
    AST_NO_DONE_WAITING: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rvalid) |=> !done); // R10
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   instr,
    input  logic                idx_ctl,
    input  logic                ld_en,
    input  logic [WORD_W-1:0]   ld_word,
    input  logic                mt_leave,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   ea
);
    fields_t cmd_f;
    fields_t mem_f;
    fields_t ld_f;
    tag_t    rd_tag;
    addr_t   ct;
    logic    multi;

    assign cmd_f = split_word(instr);
    assign mem_f = split_word(mem_rdata);
    assign ld_f  = split_word(ld_word);

    ea_xrf i_xrf (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_tag (ld_f.tag),
        .ld_val (ld_f.dec),
        .leave  (mt_leave),
        .rd_tag (rd_tag),
        .rd_val (ct),
        .multi  (multi)
    );

    ea_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_f      (cmd_f),
        .idx_ctl    (idx_ctl),
        .mem_rvalid (mem_rvalid),
        .mem_f      (mem_f),
        .ct         (ct),
        .rd_tag     (rd_tag),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .ea         (ea)
    );

    AST_RESET_MODE: assert property (@(posedge clk)
        rst |=> multi); // R1
endmodule

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [35:0] instr = '0;
    logic        idx_ctl = 1'b0;
    logic        ld_en = 1'b0;
    logic [35:0] ld_word = '0;
    logic        mt_leave = 1'b0;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic [14:0] ea;

    int    total = 0;
    int    bad = 0;
    bit    fin = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_xr[8];
    bit m_mt = 1;
    bit m_busy = 0, m_done = 0, m_req = 0;
    int m_ea = 0, m_maddr = 0;

    always #2.5 clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .idx_ctl(idx_ctl),
        .ld_en(ld_en), .ld_word(ld_word), .mt_leave(mt_leave),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea)
    );

    function automatic logic [35:0] mkw(bit [1:0] fl, bit [2:0] t, bit [14:0] y, bit [15:0] junk);
        logic [35:0] w;
        w = '0;
        w[35:24] = junk[15:4];
        w[23:22] = fl;
        w[21:18] = junk[3:0];
        w[17:15] = t;
        w[14:0]  = y;
        return w;
    endfunction

    function automatic logic [35:0] mem_word(logic [14:0] a);
        return mkw(a[0] ? 2'b11 : 2'b00, a[3:1], 15'((int'(a) * 37 + 5) & 'h7fff),
                   16'(int'(a) * 13 + 'h9c3));
    endfunction

    function automatic int mct(int t);
        int r;
        r = 0;
        if (m_mt) begin
            if (t % 2 == 1) r = r | m_xr[1];
            if ((t / 2) % 2 == 1) r = r | m_xr[2];
            if (t >= 4) r = r | m_xr[4];
        end else if (t != 0) begin
            r = m_xr[t];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        int y, t, fl, v;
        if (rst) begin
            foreach (m_xr[k]) m_xr[k] = 0;
            m_mt = 1; m_busy = 0; m_done = 0; m_req = 0; m_ea = 0; m_maddr = 0;
        end else begin
            m_done = 0;
            m_req = 0;
            if (!m_busy) begin
                if (start) begin
                    y = int'(instr[14:0]); t = int'(instr[17:15]); fl = int'(instr[23:22]);
                    if (idx_ctl) begin
                        m_ea = y; m_done = 1;
                    end else if (fl == 3) begin
                        m_maddr = (y - mct(t)) & 'h7fff; m_req = 1; m_busy = 1;
                    end else begin
                        m_ea = (y - mct(t)) & 'h7fff; m_done = 1;
                    end
                end
            end else if (mem_rvalid) begin
                m_ea = (int'(mem_rdata[14:0]) - mct(int'(mem_rdata[17:15]))) & 'h7fff;
                m_done = 1; m_busy = 0;
            end
            if (ld_en) begin
                t = int'(ld_word[17:15]); v = int'(ld_word[32:18]);
                if (m_mt) begin
                    if (t % 2 == 1) m_xr[1] = v;
                    if ((t / 2) % 2 == 1) m_xr[2] = v;
                    if (t >= 4) m_xr[4] = v;
                end else if (t != 0) begin
                    m_xr[t] = v;
                end
            end
            if (mt_leave) m_mt = 0;
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !fin) begin
            chk(done == m_done, "done", int'(done), int'(m_done));
            chk(busy == m_busy, "busy", int'(busy), int'(m_busy));
            chk(mem_req == m_req, "mem_req", int'(mem_req), int'(m_req));
            if (m_req) chk(int'(mem_addr) == m_maddr, "mem_addr", int'(mem_addr), m_maddr);
            chk(int'(ea) == m_ea, "ea", int'(ea), m_ea);
        end
    end

    // memory with fixed one-cycle read latency
    always @(negedge clk) begin
        if (mem_req) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_word(mem_addr);
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
        end
    end

    task automatic issue(logic [35:0] w, bit ic);
        start = 1'b1; instr = w; idx_ctl = ic;
        @(negedge clk);
        start = 1'b0; idx_ctl = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load(bit [2:0] t, bit [14:0] v);
        ld_en = 1'b1;
        ld_word = {3'b101, v, t, 15'h2aaa};
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        issue(mkw(0, 7, 15'h1234, 16'h0), 0);

        cur_req = "R8";
        load(3, 15'h0003);
        load(2, 15'h0120);
        load(4, 15'h1400);
        load(0, 15'h5555);

        cur_req = "R4";
        for (int t = 0; t < 8; t++) issue(mkw(0, 3'(t), 15'(16'h2345 + t * 111), 16'h0), 0);
        issue(mkw(0, 7, 15'h0005, 16'h0), 0);

        cur_req = "R2";
        for (int k = 0; k < 6; k++)
            issue(mkw(2'(k % 3), 3'(k), 15'(k * 4099 + 7), 16'(16'hffff - k * 4660)), 0);

        cur_req = "R3";
        start = 1'b1; instr = mkw(0, 0, 15'h0abc, 16'h1111);
        @(negedge clk);
        instr = mkw(1, 6, 15'h0def, 16'h2222);
        @(negedge clk);
        instr = mkw(2, 1, 15'h0010, 16'h3333);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);

        cur_req = "R6";
        issue(mkw(3, 5, 15'h0777, 16'h0), 1);
        issue(mkw(1, 3, 15'h7001, 16'hfeed), 1);

        cur_req = "R7";
        for (int k = 0; k < 6; k++) issue(mkw(3, 3'(k), 15'(k * 911 + 40), 16'h0), 0);

        cur_req = "R10";
        start = 1'b1; instr = mkw(3, 2, 15'h0321, 16'h0);
        @(negedge clk);
        instr = mkw(0, 1, 15'h0444, 16'h0);
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);

        cur_req = "R9";
        ld_en = 1'b1; ld_word = {3'b0, 15'h0700, 3'd1, 15'h0};
        start = 1'b1; instr = mkw(0, 1, 15'h1000, 16'h0);
        @(negedge clk);
        ld_en = 1'b0; start = 1'b0;
        issue(mkw(0, 1, 15'h1000, 16'h0), 0);
        start = 1'b1; instr = mkw(3, 0, 15'h0005, 16'h0);
        @(negedge clk);
        start = 1'b0;
        ld_en = 1'b1; ld_word = {3'b0, 15'h0050, 3'd2, 15'h0};
        @(negedge clk);
        ld_en = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        mt_leave = 1'b1; start = 1'b1; instr = mkw(0, 7, 15'h6000, 16'h0);
        @(negedge clk);
        mt_leave = 1'b0; start = 1'b0;
        issue(mkw(0, 7, 15'h6000, 16'h0), 0);

        cur_req = "R5";
        load(3, 15'h0333);
        load(5, 15'h0055);
        load(6, 15'h0606);
        load(7, 15'h7777);
        load(0, 15'h1111);
        for (int t = 0; t < 8; t++) issue(mkw(0, 3'(t), 15'h4000, 16'h0), 0);
        for (int k = 0; k < 4; k++) issue(mkw(3, 3'(k + 4), 15'(k * 301 + 9), 16'h0), 0);

        cur_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        issue(mkw(0, 3, 15'h0100, 16'h0), 0);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            total++;
            bad++;
            $display("FAIL %s watchdog act=%0d exp=%0d", cur_req, 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule